// File: doc/BRIEF.md
# Display RAM Bit-Plane Selector

This block feeds the segment register of a multiplexed LCD driver. The segment memory holds 24 words of 4 bits. Each multiplex time slot uses one bit plane, which is the same bit position taken from every word. The block follows the active drive mode to decide which planes are shown and in what order. It walks through them one slot at a time, each time the frame timing sends a slot-advance tick.

In static and 1:2 modes only half of each word is displayed. An alternate-bank select moves the display to the upper half of each word. Software can then build a new picture in the upper half and switch to it in one step. A change of the bank select is taken up only when a new frame begins, that is, when the slot counter enters slot 0, so a frame never mixes both halves. The segment vector is registered. It changes on the clock edge that samples a tick or a mode change, and holds steady at every other edge.

Top module: `plane_selector`

## Requirements
- R1: While rst_ni is low and after its release, until the first load, seg_o is all zero and bp_o is 0.
- R2: The mode_i encoding is 0 static, 1 1:2, 2 1:3, 3 1:4. With the mode held, each cycle that has tick_i high moves bp_o to the next slot, wrapping from slot mode_i back to 0.
- R3: In 1:4 mode, slot k shows plane k. The planes run 0,1,2,3 and then repeat.
- R4: In 1:3 mode, slot k shows plane k. The planes run 0,1,2 and then repeat.
- R5: With bank_i low, the display uses plane 0 in static mode and planes 0 and 1 in slots 0 and 1 of 1:2 mode.
- R6: In static mode with the alternate bank active, plane 2 replaces plane 0.
- R7: In 1:2 mode with the alternate bank active, planes 2 and 3 replace planes 0 and 1.
- R8: bank_i has no effect on the display in 1:3 or 1:4 mode.
- R9: bank_i is sampled only when the slot counter enters slot 0, through a wrap or a mode change. A change made in the middle of a frame is not seen until the next frame.
- R10: A cycle in which mode_i differs from its value in the previous cycle sets bp_o to 0 and reloads the segments for slot 0 of the new mode. This takes priority over a tick in the same cycle.
- R11: seg_o is registered. It changes only on the edge that samples a tick or a mode change, and stays unchanged when ram_i changes at any other time.
- R12: Word a of the memory sits at ram_i[4a+3:4a], with bit p of that word being plane p. seg_o[a] comes from word a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Drive mode (0 static, 1 1:2, 2 1:3, 3 1:4) |
| bank_i | input | 1 | Alternate output bank request |
| tick_i | input | 1 | Slot-advance strobe from frame timing |
| ram_i | input | 96 | Flat read port, 24 words of 4 bits |
| seg_o | output | 24 | Registered segment vector |
| bp_o | output | 2 | Current backplane (slot) index |

## Verification
The bench puts the bank select through changes in the middle of a frame in static and 1:2 modes. A design that applied the bank at once would show planes 2 and 3 mixed into a frame, or would switch halves within a frame. It also changes the mode in the same cycle as a tick, and in the middle of a frame. A design that let the tick win, or that kept the old slot count, would start the new mode at slot 1 or run past the shortened ratio. The memory contents are changed between ticks, which catches a segment path that is not registered. Bank toggling in 1:3 and 1:4 modes catches a remap that leaks out of the two modes it belongs to.

// File: rtl/plane_sel_pkg.sv
package plane_sel_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } drive_mode_e;
endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl #(
  parameter int PLANES = 4,
  localparam int SW = $clog2(PLANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          bank_i,
  input  logic          tick_i,
  output logic [SW-1:0] slot_o,
  output logic [SW-1:0] slot_nxt_o,
  output logic          bank_nxt_o,
  output logic          load_o
);
  logic [1:0]    mode_q;
  logic [SW-1:0] slot_q, last_slot;
  logic          bank_q, mode_chg;

  assign mode_chg  = mode_i != mode_q;
  assign last_slot = SW'(mode_i);

  always_comb begin
    slot_nxt_o = slot_q;
    bank_nxt_o = bank_q;
    load_o     = 1'b0;
    if (mode_chg) begin
      slot_nxt_o = '0;
      bank_nxt_o = bank_i;
      load_o     = 1'b1;
    end else if (tick_i) begin
      load_o = 1'b1;
      if (slot_q >= last_slot) begin
        slot_nxt_o = '0;
        bank_nxt_o = bank_i;   // new frame: bank taken up here only
      end else begin
        slot_nxt_o = slot_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      slot_q <= '0;
      bank_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      slot_q <= slot_nxt_o;
      bank_q <= bank_nxt_o;
    end
  end

  assign slot_o = slot_q;

  // R2
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SW'(mode_q));
  // R2
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !mode_chg && slot_q == last_slot) |=> slot_q == '0);
  // R10
  mode_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> slot_q == '0);
  // R9
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != '0) |-> $stable(bank_q));
endmodule

// File: rtl/plane_map.sv
module plane_map
  import plane_sel_pkg::*;
#(
  parameter int PLANES = 4,
  localparam int SW = $clog2(PLANES)
) (
  input  logic [1:0]    mode_i,
  input  logic [SW-1:0] slot_i,
  input  logic          bank_i,
  output logic [SW-1:0] plane_o
);
  logic [SW-1:0] bank_off;
  assign bank_off = bank_i ? SW'(PLANES / 2) : '0;

  always_comb begin
    unique case (drive_mode_e'(mode_i))
      MODE_STATIC: plane_o = bank_off;
      MODE_MUX2:   plane_o = bank_off + SW'(slot_i[0]);
      default:     plane_o = slot_i;
    endcase
  end
endmodule

// File: rtl/plane_mux.sv
module plane_mux #(
  parameter int NUM_ADDR = 24,
  parameter int PLANES   = 4,
  localparam int SW = $clog2(PLANES)
) (
  input  logic [NUM_ADDR*PLANES-1:0] ram_i,
  input  logic [SW-1:0]              plane_i,
  output logic [NUM_ADDR-1:0]        seg_o
);
  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_addr
    logic [PLANES-1:0] word;
    assign word     = ram_i[a*PLANES +: PLANES];
    assign seg_o[a] = word[plane_i];
  end
endmodule

// File: rtl/plane_selector.sv
module plane_selector
  import plane_sel_pkg::*;
#(
  parameter int NUM_ADDR = 24,
  parameter int PLANES   = 4,
  localparam int SW = $clog2(PLANES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 mode_i,
  input  logic                       bank_i,
  input  logic                       tick_i,
  input  logic [NUM_ADDR*PLANES-1:0] ram_i,
  output logic [NUM_ADDR-1:0]        seg_o,
  output logic [SW-1:0]              bp_o
);
  logic [SW-1:0]       slot_nxt, plane;
  logic                bank_nxt, load;
  logic [NUM_ADDR-1:0] seg_d, seg_q;

  slot_ctrl #(.PLANES(PLANES)) u_ctrl (
    .clk_i, .rst_ni, .mode_i, .bank_i, .tick_i,
    .slot_o(bp_o), .slot_nxt_o(slot_nxt), .bank_nxt_o(bank_nxt), .load_o(load)
  );

  plane_map #(.PLANES(PLANES)) u_map (
    .mode_i, .slot_i(slot_nxt), .bank_i(bank_nxt), .plane_o(plane)
  );

  plane_mux #(.NUM_ADDR(NUM_ADDR), .PLANES(PLANES)) u_mux (
    .ram_i, .plane_i(plane), .seg_o(seg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   seg_q <= '0;
    else if (load) seg_q <= seg_d;
  end

  assign seg_o = seg_q;

  // R11
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(seg_q));
  // R8
  no_remap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && mode_i[1]) |-> plane == slot_nxt);
  // R6 R7
  bank_plane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !mode_i[1] && bank_nxt) |-> plane >= SW'(PLANES / 2));
endmodule

// File: tb/plane_selector_test.sv
module plane_selector_test;
  localparam int NA = 24;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          bank = 1'b0;
  logic          tick = 1'b0;
  logic [NA*NP-1:0] ram = '0;
  logic [NA-1:0] seg;
  logic [1:0]    bp;

  int vectors = 0;
  int fails   = 0;

  // reference state
  int m_prev = 0, m_slot = 0, m_bank = 0;
  logic [NA-1:0] m_seg = '0;

  always #4 clk = ~clk;

  plane_selector uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .bank_i(bank),
    .tick_i(tick), .ram_i(ram), .seg_o(seg), .bp_o(bp)
  );

  task automatic compare(input string tag);
    vectors++;
    if (seg !== m_seg || bp !== 2'(m_slot)) begin
      fails++;
      $display("FAIL %s: seg=%h bp=%0d expected seg=%h bp=%0d", tag, seg, bp, m_seg, m_slot);
    end
  endtask

  task automatic step(input logic t, input logic b, input int m, input string tag);
    int pl;
    bit ld;
    tick = t; bank = b; mode = 2'(m);
    @(posedge clk);
    ld = 0;
    if (m != m_prev) begin
      m_slot = 0; m_bank = b; ld = 1;
    end else if (t) begin
      ld = 1;
      if (m_slot >= m) begin m_slot = 0; m_bank = b; end
      else m_slot = m_slot + 1;
    end
    m_prev = m;
    if (ld) begin
      if (m == 0)      pl = m_bank ? 2 : 0;
      else if (m == 1) pl = m_slot + (m_bank ? 2 : 0);
      else             pl = m_slot;
      for (int a = 0; a < NA; a++) m_seg[a] = ram[a*NP + pl];
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic new_ram();
    for (int w = 0; w < NP*NA/32; w++) ram[w*32 +: 32] = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    new_ram();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_ni = 1'b1;
    step(0, 0, 0, "R1 after release");

    // R12 single-bit patterns: walking one per word, per plane
    for (int p = 0; p < NP; p++) begin
      ram = '0;
      for (int a = 0; a < NA; a += 5) ram[a*NP + p] = 1'b1;
      step(0, 0, 3, "R12 setup");
      for (int s = 0; s < 8; s++) step(1, 0, 3, "R12 R3 word order");
    end

    // R3 1:4 with bank toggling (R8)
    new_ram();
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 0) new_ram();
      step(i % 2, i % 3 == 0, 3, "R3 R8 1:4");
    end
    // R4 1:3
    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 0) new_ram();
      step(i % 3 != 2, i % 4 < 2, 2, "R4 R8 1:3");
    end
    // R5 static and 1:2 without bank
    for (int i = 0; i < 20; i++) begin new_ram(); step(i % 2, 0, 0, "R5 static"); end
    for (int i = 0; i < 20; i++) begin new_ram(); step(1, 0, 1, "R5 R2 1:2"); end
    // R6 static with bank
    for (int i = 0; i < 20; i++) begin new_ram(); step(1, i >= 6, 0, "R6 static bank"); end
    // R7 R9 1:2 bank flipped mid-frame
    for (int i = 0; i < 30; i++) begin
      new_ram();
      step(i % 2, (i / 3) % 2, 1, "R7 R9 1:2 bank");
    end
    // R10 mode change with and without tick, mid-frame
    step(1, 0, 3, "R10 prep");
    step(1, 0, 3, "R10 prep");
    step(1, 0, 3, "R10 prep");
    step(1, 1, 1, "R10 change with tick");
    step(1, 1, 1, "R10 after");
    step(0, 1, 2, "R10 change no tick");
    step(1, 1, 2, "R10 after");
    step(1, 0, 0, "R10 change to static");
    step(1, 0, 3, "R10 change to 1:4");
    // R11 ram changes without load
    for (int i = 0; i < 20; i++) begin
      new_ram();
      step(i % 4 == 0, 0, 3, "R11 hold");
    end
    // R2 long runs, every mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 50; i++) begin
        if (i % 9 == 0) new_ram();
        step(i % 3 == 0 || i % 5 == 0, i % 11 < 4, m, "R2 sweep");
      end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule